// File: doc/BRIEF.md
# I2C Bus Condition and Arbitration Monitor

This block sits beside an I2C controller on a multi-master, wired-AND bus. It watches the clock and data lines, brings them into the system clock domain and reports every START, repeated START and STOP condition as a one-cycle pulse. It keeps a busy flag that runs from a START to the following STOP. A free flag rises only after both lines have stayed high for a bus-free interval. That interval is counted in system clock cycles, and its length is chosen by a speed-mode input.

While the local master is active, the block compares what the master drives with what the bus carries. The master may release a line (not pull it low) and still see that line low. Another device then owns the bus, and the block raises an arbitration-lost pulse. The drive enables are delayed through as many stages as the line synchronizer. The comparison therefore always pairs a drive value with the bus sample that it produced.

Top module: `i2c_bus_watch`

## Requirements
- R1: Each raw line passes through SYNC_STAGES flops (default 2) before condition logic. A line change driven before clock edge k shows up as a condition pulse in the cycle after edge k+1.
- R2: A falling data line while the clock line is high, in both the current and the previous synchronized sample, gives `start_pulse` high for exactly one cycle.
- R3: A rising data line while the clock line is high gives `stop_pulse` high for exactly one cycle.
- R4: `bus_busy` goes to 1 on the edge after a START pulse and to 0 on the edge after a STOP pulse. It is 0 after reset.
- R5: A START seen while `bus_busy` is 1 also raises `rstart_pulse` in the same cycle as `start_pulse`. A START on an idle bus leaves `rstart_pulse` at 0.
- R6: Data-line changes while the clock line is low, and clock-line changes, produce no START or STOP pulse and leave `bus_busy` unchanged.
- R7: `bus_free` is 0 after reset. With both lines high from reset, it rises after FREE_CYC_STD edges (`fast_mode`=0) or FREE_CYC_FAST edges (`fast_mode`=1).
- R8: Either synchronized line low clears the free count. When both lines go high again, `bus_free` rises after limit+SYNC_STAGES edges, where limit is the threshold selected by `fast_mode`. `bus_free` is never 1 while `bus_busy` is 1.
- R9: With `master_active` high, a released data line that reads low gives `arb_lost_pulse` for one cycle. The line staying low gives no further pulse.
- R10: With `master_active` high, a released clock line that reads low gives `arb_lost_pulse` for one cycle.
- R11: There is no arbitration-lost pulse when `master_active` is low, when the local master itself drives the line low, or in the cycles after it releases a line that then goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw clock line as read from the pad |
| sda_in | input | 1 | Raw data line as read from the pad |
| scl_drive_low | input | 1 | Local master pulls the clock line low |
| sda_drive_low | input | 1 | Local master pulls the data line low |
| master_active | input | 1 | Local master is taking part on the bus |
| fast_mode | input | 1 | 0 selects the standard free time, 1 the fast free time |
| start_pulse | output | 1 | One-cycle START (or repeated START) indication |
| rstart_pulse | output | 1 | One-cycle repeated START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| arb_lost_pulse | output | 1 | One-cycle arbitration-lost indication |
| bus_busy | output | 1 | Bus held between START and STOP |
| bus_free | output | 1 | Both lines idle for the selected free time |

## Verification
A line change driven before edge k gives condition and arbitration pulses in the cycle after edge k+1. The bench samples 2 ns after that second edge, and again one edge later, to confirm that each pulse lasts one cycle and that `bus_busy` follows it. The free flag is due limit+2 edges after both lines return high, or limit edges after reset. The bench counts edges from the drive up to the rise of `bus_free` and compares the count with that figure in both speed modes. The bench also counts pulses at every clock edge. The absence of a pulse during data bits, during a driven-low line or while the master is inactive is then checked from the change in those counts.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    typedef enum logic {
        SPEED_STD  = 1'b0,
        SPEED_FAST = 1'b1
    } speed_e;

    localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};
    localparam bus_lines_t DRIVE_NONE = '{scl: 1'b0, sda: 1'b0};

    function automatic int unsigned free_cnt_width(input int unsigned a, input int unsigned b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_watch_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t raw,
    output bus_lines_t synced
);
    bus_lines_t stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= LINES_IDLE;
                    else     stage_q[i] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= LINES_IDLE;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_watch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t lines,
    output logic       start_o,
    output logic       rstart_o,
    output logic       stop_o,
    output logic       busy_o
);
    bus_lines_t prev_q;
    logic       busy_q;
    logic       clk_high;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= LINES_IDLE;
        else     prev_q <= lines;
    end

    assign clk_high = prev_q.scl & lines.scl;
    assign start_o  = clk_high &  prev_q.sda & ~lines.sda;
    assign stop_o   = clk_high & ~prev_q.sda &  lines.sda;
    assign rstart_o = start_o & busy_q;

    always_ff @(posedge clk) begin
        if (rst)          busy_q <= 1'b0;
        else if (start_o) busy_q <= 1'b1;
        else if (stop_o)  busy_q <= 1'b0;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/i2c_free_timer.sv
module i2c_free_timer
    import i2c_watch_pkg::*;
#(
    parameter int unsigned STD_CYC  = 470,
    parameter int unsigned FAST_CYC = 130
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t lines,
    input  speed_e     speed,
    input  logic       busy,
    output logic       free_o
);
    localparam int unsigned CW = free_cnt_width(STD_CYC, FAST_CYC);
    localparam logic [CW-1:0] STD_LIM  = CW'(STD_CYC);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_CYC);
    localparam logic [CW-1:0] CNT_TOP  = (STD_LIM > FAST_LIM) ? STD_LIM : FAST_LIM;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = (speed == SPEED_FAST) ? FAST_LIM : STD_LIM;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= '0;
        else if (!(lines.scl && lines.sda)) cnt_q <= '0;
        else if (cnt_q != CNT_TOP)      cnt_q <= cnt_q + 1'b1;
    end

    assign free_o = (cnt_q >= limit) && !busy;
endmodule

// File: rtl/i2c_arb_check.sv
module i2c_arb_check
    import i2c_watch_pkg::*;
#(
    parameter int unsigned DELAY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_lines_t lines,
    input  bus_lines_t drive_low,
    input  logic       active,
    output logic       lost_o
);
    bus_lines_t drv_q [DELAY];
    logic       raw_lost;
    logic       lost_q;

    generate
        for (genvar i = 0; i < DELAY; i++) begin : g_dly
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) drv_q[i] <= DRIVE_NONE;
                    else     drv_q[i] <= drive_low;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) drv_q[i] <= DRIVE_NONE;
                    else     drv_q[i] <= drv_q[i-1];
                end
            end
        end
    endgenerate

    assign raw_lost = active &
                      ((~drv_q[DELAY-1].sda & ~lines.sda) |
                       (~drv_q[DELAY-1].scl & ~lines.scl));

    always_ff @(posedge clk) begin
        if (rst) lost_q <= 1'b0;
        else     lost_q <= raw_lost;
    end

    assign lost_o = raw_lost & ~lost_q;
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned FREE_CYC_STD  = 470,
    parameter int unsigned FREE_CYC_FAST = 130
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    input  logic scl_drive_low,
    input  logic sda_drive_low,
    input  logic master_active,
    input  logic fast_mode,
    output logic start_pulse,
    output logic rstart_pulse,
    output logic stop_pulse,
    output logic arb_lost_pulse,
    output logic bus_busy,
    output logic bus_free
);
    bus_lines_t raw_lines;
    bus_lines_t sync_lines;
    bus_lines_t local_drv;
    speed_e     speed_sel;

    assign raw_lines = '{scl: scl_in, sda: sda_in};
    assign local_drv = '{scl: scl_drive_low, sda: sda_drive_low};
    assign speed_sel = fast_mode ? SPEED_FAST : SPEED_STD;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_lines),
        .synced (sync_lines)
    );

    i2c_cond_detect u_cond (
        .clk      (clk),
        .rst      (rst),
        .lines    (sync_lines),
        .start_o  (start_pulse),
        .rstart_o (rstart_pulse),
        .stop_o   (stop_pulse),
        .busy_o   (bus_busy)
    );

    i2c_free_timer #(.STD_CYC(FREE_CYC_STD), .FAST_CYC(FREE_CYC_FAST)) u_free (
        .clk    (clk),
        .rst    (rst),
        .lines  (sync_lines),
        .speed  (speed_sel),
        .busy   (bus_busy),
        .free_o (bus_free)
    );

    i2c_arb_check #(.DELAY(SYNC_STAGES)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .lines     (sync_lines),
        .drive_low (local_drv),
        .active    (master_active),
        .lost_o    (arb_lost_pulse)
    );
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
    input logic clk,
    input logic rst,
    input logic master_active,
    input logic start_pulse,
    input logic rstart_pulse,
    input logic stop_pulse,
    input logic arb_lost_pulse,
    input logic bus_busy,
    input logic bus_free
);
    // R4
    busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> bus_busy);

    // R4
    idle_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_pulse && !start_pulse) |=> !bus_busy);

    // R4
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> $past(start_pulse));

    // R5
    rstart_context_chk: assert property (@(posedge clk) disable iff (rst)
        rstart_pulse |-> (start_pulse && bus_busy));

    // R8
    free_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        bus_free |-> !bus_busy);

    // R9
    arb_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost_pulse |=> !arb_lost_pulse);

    // R11
    arb_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
        arb_lost_pulse |-> master_active);
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .master_active  (master_active),
    .start_pulse    (start_pulse),
    .rstart_pulse   (rstart_pulse),
    .stop_pulse     (stop_pulse),
    .arb_lost_pulse (arb_lost_pulse),
    .bus_busy       (bus_busy),
    .bus_free       (bus_free)
);

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;
    localparam int unsigned STD_L  = 12;
    localparam int unsigned FAST_L = 5;
    localparam int unsigned SYNC_N = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oth_scl_low = 1'b0, oth_sda_low = 1'b0;
    logic loc_scl_low = 1'b0, loc_sda_low = 1'b0;
    logic master_active = 1'b0;
    logic fast_mode = 1'b0;
    logic scl_in, sda_in;
    logic start_pulse, rstart_pulse, stop_pulse, arb_lost_pulse, bus_busy, bus_free;

    int n_tests = 0;
    int n_fail  = 0;
    int n_start = 0, n_rstart = 0, n_stop = 0, n_arb = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    assign scl_in = ~(oth_scl_low | loc_scl_low);
    assign sda_in = ~(oth_sda_low | loc_sda_low);

    i2c_bus_watch #(
        .SYNC_STAGES(SYNC_N), .FREE_CYC_STD(STD_L), .FREE_CYC_FAST(FAST_L)
    ) u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(loc_scl_low), .sda_drive_low(loc_sda_low),
        .master_active(master_active), .fast_mode(fast_mode),
        .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
        .stop_pulse(stop_pulse), .arb_lost_pulse(arb_lost_pulse),
        .bus_busy(bus_busy), .bus_free(bus_free)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (start_pulse)    n_start++;
            if (rstart_pulse)   n_rstart++;
            if (stop_pulse)     n_stop++;
            if (arb_lost_pulse) n_arb++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_set(input logic scl, input logic sda);
        @(negedge clk);
        oth_scl_low = ~scl;
        oth_sda_low = ~sda;
    endtask

    task automatic measure_free(output int m);
        m = 0;
        while (!bus_free && m < 1000) begin
            step(1);
            m++;
        end
    endtask

    int m, s0, p0, r0, a0;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R4 R7: reset state
        chk("R4 busy after reset", int'(bus_busy), 0);
        chk("R7 free after reset", int'(bus_free), 0);
        measure_free(m);
        chk("R7 std free time from reset", m, STD_L);

        // R1 R2: START on idle bus
        s0 = n_start; r0 = n_rstart;
        bus_set(1'b1, 1'b0);
        step(1);
        chk("R1 no pulse after one edge", int'(start_pulse), 0);
        step(1);
        chk("R2 start pulse", int'(start_pulse), 1);
        chk("R5 no rstart on idle", int'(rstart_pulse), 0);
        chk("R4 busy not yet", int'(bus_busy), 0);
        step(1);
        chk("R2 start one cycle", int'(start_pulse), 0);
        chk("R4 busy set", int'(bus_busy), 1);
        chk("R8 free low while busy", int'(bus_free), 0);

        // R6: data byte 0xA5 with SDA moving only while SCL low
        s0 = n_start; p0 = n_stop;
        for (int b = 7; b >= 0; b--) begin
            bus_set(1'b0, sda_in);
            bus_set(1'b0, ((8'hA5 >> b) & 1) != 0);
            bus_set(1'b1, ((8'hA5 >> b) & 1) != 0);
            step(2);
        end
        bus_set(1'b0, sda_in);
        step(3);
        chk("R6 no start during data", n_start - s0, 0);
        chk("R6 no stop during data", n_stop - p0, 0);
        chk("R6 busy held", int'(bus_busy), 1);

        // R5: repeated START
        s0 = n_start; r0 = n_rstart;
        bus_set(1'b0, 1'b1);
        bus_set(1'b1, 1'b1);
        bus_set(1'b1, 1'b0);
        step(2);
        chk("R5 rstart pulse", int'(rstart_pulse), 1);
        step(2);
        chk("R5 rstart count", n_rstart - r0, 1);
        chk("R5 start count", n_start - s0, 1);
        chk("R4 busy after rstart", int'(bus_busy), 1);

        // R3 R4 R8: STOP, then fast free time
        fast_mode = 1'b1;
        bus_set(1'b0, 1'b0);
        bus_set(1'b1, 1'b0);
        step(3);
        p0 = n_stop;
        bus_set(1'b1, 1'b1);
        step(2);
        chk("R3 stop pulse", int'(stop_pulse), 1);
        step(1);
        chk("R3 stop one cycle", int'(stop_pulse), 0);
        chk("R4 busy cleared", int'(bus_busy), 0);
        chk("R3 stop count", n_stop - p0, 1);
        measure_free(m);
        chk("R8 fast free after stop", m + 3, FAST_L + SYNC_N);

        // R8 sweep: modes x hold lengths
        for (int md = 0; md < 2; md++) begin
            for (int h = 3; h <= 6; h += 3) begin
                fast_mode = (md != 0);
                bus_set(1'b0, 1'b1);
                step(h);
                chk("R8 free low on line low", int'(bus_free), 0);
                bus_set(1'b1, 1'b1);
                measure_free(m);
                chk("R8 free time sweep", m, (md != 0 ? FAST_L : STD_L) + SYNC_N);
                chk("R6 scl pulses leave busy", int'(bus_busy), 0);
            end
        end

        // R9: released SDA pulled low by another master
        master_active = 1'b1;
        step(4);
        a0 = n_arb;
        bus_set(1'b1, 1'b0);
        step(2);
        chk("R9 arb pulse on sda", int'(arb_lost_pulse), 1);
        step(1);
        chk("R9 arb one cycle", int'(arb_lost_pulse), 0);
        step(4);
        chk("R9 single pulse while held", n_arb - a0, 1);
        bus_set(1'b1, 1'b1);
        step(4);

        // R11: local drives low together with the other master
        a0 = n_arb;
        @(negedge clk); loc_sda_low = 1'b1; oth_sda_low = 1'b1;
        step(5);
        chk("R11 no arb while driving low", n_arb - a0, 0);
        // R9: release while other still low
        @(negedge clk); loc_sda_low = 1'b0;
        step(2);
        chk("R9 arb on release into low", int'(arb_lost_pulse), 1);
        bus_set(1'b1, 1'b1);
        step(4);

        // R11: local drives low alone then releases
        a0 = n_arb;
        @(negedge clk); loc_sda_low = 1'b1;
        step(4);
        @(negedge clk); loc_sda_low = 1'b0;
        step(5);
        chk("R11 no arb on clean release", n_arb - a0, 0);

        // R10: released SCL held low by another device
        a0 = n_arb;
        bus_set(1'b0, 1'b1);
        step(2);
        chk("R10 arb pulse on scl", int'(arb_lost_pulse), 1);
        step(3);
        chk("R10 single scl pulse", n_arb - a0, 1);
        bus_set(1'b1, 1'b1);
        step(4);

        // R11: inactive master ignores a low line
        master_active = 1'b0;
        a0 = n_arb;
        bus_set(1'b1, 1'b0);
        step(5);
        bus_set(1'b0, 1'b0);
        step(5);
        chk("R11 no arb when inactive", n_arb - a0, 0);
        bus_set(1'b1, 1'b0);
        bus_set(1'b1, 1'b1);
        step(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule